// File: doc/BRIEF.md
# Power Transition Step Wait Monitor

This block watches one step of a power state change at a time. A sequencer starts a step and gives it a step identifier, a transition kind and a mode. The monitor then reports completion, or it reports an abnormal step together with a code that names the step.

A step runs in one of two modes. In handshake mode the step waits until a handshake line, brought in through a synchronizer, reaches an expected level. After that it waits a settle count and then finishes. In count mode the handshake is not watched, and the step finishes once its settle count has run out. Software can program one settle count for each transition kind, so that slow modules get long waits and fast modules get short ones. A separate timeout counter covers every step from the moment it starts.

Top module: `step_wait_monitor`

## Requirements
- R1: While `rst_n` is low and right after it rises, `busy`, `done` and `error` are low and `err_code` is zero.
- R2: A step is accepted at a rising clock edge where `start` is high and `busy` is low. With `step_mode` = 1 (count mode) and a settle count N, `done` is high for the clock cycle that follows the N+1-th edge after the accepting edge. The level of `hs_in` has no effect in this mode.
- R3: With `step_mode` = 0 (handshake mode), `done` needs the synchronized `hs_in` to equal `exp_level`. If `hs_in` already matches when the step is accepted, `done` follows edge N+2. If `hs_in` changes right after edge d, `done` follows edge d+N+4. This counts two synchronizer stages.
- R4: There is one settle count register for each value of `step_kind`, written through `cnt_wr_en`/`cnt_wr_kind`/`cnt_wr_val`. A step reads the register of its own kind when it is accepted. A write made while a step runs changes only later steps. The same holds for the timeout register written through `tmo_wr_en`/`tmo_wr_val`.
- R5: After reset, every settle count register reads all ones (65535 with 16 bits) and the timeout register reads all ones.
- R6: With a timeout limit T, a step that has not finished by edge T+1 raises `error` for one cycle after that edge and raises no `done`. `err_code` then takes the step's `step_id` and keeps it until the next error. If completion and timeout fall on the same edge, `done` wins and `error` stays low.
- R7: A `start` that arrives while `busy` is high is ignored. It does not change when the running step finishes, and it starts no extra step.
- R8: `done` and `error` are single-cycle pulses that never occur together. `busy` is high from the edge that accepts a step until the edge that raises `done` or `error`, and it is low in the cycle of the pulse.
- R9: A settle count of zero finishes the step one cycle after its condition is met: in count mode, `done` follows the first edge after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_wr_en | input | 1 | Write strobe for a settle count register |
| cnt_wr_kind | input | $clog2(NUM_KINDS) | Settle count register selected for the write |
| cnt_wr_val | input | CNT_W | Settle count value to write |
| tmo_wr_en | input | 1 | Write strobe for the timeout limit |
| tmo_wr_val | input | TO_W | Timeout limit value |
| start | input | 1 | Request to begin a step |
| step_id | input | STEP_W | Identifier of the step, reported on timeout |
| step_kind | input | $clog2(NUM_KINDS) | Transition kind, selects the settle count |
| step_mode | input | 1 | 1 = count mode, 0 = handshake mode |
| exp_level | input | 1 | Handshake level that ends the wait in handshake mode |
| hs_in | input | 1 | Handshake line, possibly from another clock domain |
| busy | output | 1 | A step is in progress |
| done | output | 1 | One-cycle pulse when a step completes |
| error | output | 1 | One-cycle pulse when a step times out |
| err_code | output | STEP_W | Identifier of the step that last timed out |

## Verification
The bench uses the default parameters: 16-bit settle counts, a 20-bit timeout, four transition kinds, 6-bit step identifiers and a two-stage synchronizer. The 16-bit count keeps a never-written register (65535 cycles) within the run length, so the reset default can be timed in full. The 20-bit default timeout stays out of its way. With two synchronizer stages, the handshake latency is a fixed number of edges. This lets each completion be checked on an exact cycle, including the edge where completion and timeout coincide.

// File: rtl/swm_pkg.sv
package swm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WAIT_HS = 2'd1,
      ST_SETTLE = 2'd2
   } step_state_t;

   typedef enum logic {
      MODE_HANDSHAKE = 1'b0,
      MODE_COUNT     = 1'b1
   } step_mode_t;
endpackage

// File: rtl/swm_hs_sync.sv
module swm_hs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/swm_cnt_bank.sv
module swm_cnt_bank #(
   parameter int KINDS = 4,
   parameter int CNT_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [$clog2(KINDS)-1:0] wr_sel,
   input  logic [CNT_W-1:0]         wr_data,
   input  logic [$clog2(KINDS)-1:0] rd_sel,
   output logic [CNT_W-1:0]         rd_data
);
   localparam int SEL_W = $clog2(KINDS);

   logic [CNT_W-1:0] regs [KINDS];

   for (genvar k = 0; k < KINDS; k++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             regs[k] <= '1;
         else if (wr_en && wr_sel == SEL_W'(k))  regs[k] <= wr_data;
      end
   end

   assign rd_data = regs[rd_sel];
endmodule

// File: rtl/swm_tmo_timer.sv
module swm_tmo_timer #(
   parameter int TO_W = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [TO_W-1:0] wr_data,
   input  logic            arm,
   input  logic            run,
   output logic            expired
);
   logic [TO_W-1:0] limit_reg;
   logic [TO_W-1:0] limit_snap;
   logic [TO_W-1:0] elapsed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     limit_reg <= '1;
      else if (wr_en) limit_reg <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit_snap <= '1;
         elapsed    <= '0;
      end else if (arm) begin
         limit_snap <= limit_reg;
         elapsed    <= '0;
      end else if (run) begin
         elapsed    <= elapsed + 1'b1;
      end
   end

   assign expired = run && (elapsed == limit_snap);
endmodule

// File: rtl/swm_step_fsm.sv
module swm_step_fsm
   import swm_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int STEP_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [STEP_W-1:0] step_id,
   input  logic              step_mode,
   input  logic              exp_level,
   input  logic              hs_sync,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic              tmo_expired,
   output logic              accept,
   output logic              busy,
   output logic              done,
   output logic              error,
   output logic [STEP_W-1:0] err_code
);
   step_state_t       state;
   logic [CNT_W-1:0]  settle;
   logic [STEP_W-1:0] id_q;
   logic              exp_q;

   assign busy   = (state != ST_IDLE);
   assign accept = (state == ST_IDLE) && start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         settle   <= '0;
         id_q     <= '0;
         exp_q    <= 1'b0;
         done     <= 1'b0;
         error    <= 1'b0;
         err_code <= '0;
      end else begin
         done  <= 1'b0;
         error <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  id_q   <= step_id;
                  exp_q  <= exp_level;
                  settle <= cnt_val;
                  state  <= (step_mode == MODE_COUNT) ? ST_SETTLE : ST_WAIT_HS;
               end
            end
            ST_WAIT_HS: begin
               if (tmo_expired) begin
                  error    <= 1'b1;
                  err_code <= id_q;
                  state    <= ST_IDLE;
               end else if (hs_sync == exp_q) begin
                  state    <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (settle == '0) begin
                  done     <= 1'b1;
                  state    <= ST_IDLE;
               end else if (tmo_expired) begin
                  error    <= 1'b1;
                  err_code <= id_q;
                  state    <= ST_IDLE;
               end else begin
                  settle   <= settle - 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/step_wait_monitor.sv
module step_wait_monitor #(
   parameter int CNT_W       = 16,
   parameter int TO_W        = 20,
   parameter int NUM_KINDS   = 4,
   parameter int STEP_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cnt_wr_en,
   input  logic [$clog2(NUM_KINDS)-1:0] cnt_wr_kind,
   input  logic [CNT_W-1:0]             cnt_wr_val,
   input  logic                         tmo_wr_en,
   input  logic [TO_W-1:0]              tmo_wr_val,
   input  logic                         start,
   input  logic [STEP_W-1:0]            step_id,
   input  logic [$clog2(NUM_KINDS)-1:0] step_kind,
   input  logic                         step_mode,
   input  logic                         exp_level,
   input  logic                         hs_in,
   output logic                         busy,
   output logic                         done,
   output logic                         error,
   output logic [STEP_W-1:0]            err_code
);
   localparam int KIND_W = $clog2(NUM_KINDS);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (NUM_KINDS < 2 || (1 << KIND_W) != NUM_KINDS) begin : g_bad_kinds
      $error("NUM_KINDS must be a power of two, at least 2");
   end
   if (CNT_W < 11) begin : g_bad_cnt
      $error("CNT_W must hold settle counts of at least 2000");
   end
   if (TO_W < 1 || STEP_W < 1) begin : g_bad_width
      $error("TO_W and STEP_W must be positive");
   end

   logic             hs_sync;
   logic [CNT_W-1:0] cnt_val;
   logic             accept;
   logic             tmo_expired;

   swm_hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (hs_in),
      .q     (hs_sync)
   );

   swm_cnt_bank #(.KINDS(NUM_KINDS), .CNT_W(CNT_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cnt_wr_en),
      .wr_sel  (cnt_wr_kind),
      .wr_data (cnt_wr_val),
      .rd_sel  (step_kind),
      .rd_data (cnt_val)
   );

   swm_tmo_timer #(.TO_W(TO_W)) u_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tmo_wr_en),
      .wr_data (tmo_wr_val),
      .arm     (accept),
      .run     (busy),
      .expired (tmo_expired)
   );

   swm_step_fsm #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .step_id     (step_id),
      .step_mode   (step_mode),
      .exp_level   (exp_level),
      .hs_sync     (hs_sync),
      .cnt_val     (cnt_val),
      .tmo_expired (tmo_expired),
      .accept      (accept),
      .busy        (busy),
      .done        (done),
      .error       (error),
      .err_code    (err_code)
   );
endmodule

// File: rtl/step_wait_monitor_chk.sv
module step_wait_monitor_chk #(
   parameter int STEP_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              error,
   input logic [STEP_W-1:0] err_code
);
   // R8
   done_error_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   error_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> !error);

   // R8
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || error) |-> !busy);

   // R2
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R7
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R6
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(err_code) |-> error);
endmodule

bind step_wait_monitor step_wait_monitor_chk #(.STEP_W(STEP_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .error    (error),
   .err_code (err_code)
);

// File: tb/sim_step_wait_monitor.sv
`timescale 1ns/1ps
module sim_step_wait_monitor;
   localparam int CNT_W  = 16;
   localparam int TO_W   = 20;
   localparam int KINDS  = 4;
   localparam int STEP_W = 6;
   localparam int KW     = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cnt_wr_en = 1'b0;
   logic [KW-1:0]     cnt_wr_kind = '0;
   logic [CNT_W-1:0]  cnt_wr_val = '0;
   logic              tmo_wr_en = 1'b0;
   logic [TO_W-1:0]   tmo_wr_val = '0;
   logic              start = 1'b0;
   logic [STEP_W-1:0] step_id = '0;
   logic [KW-1:0]     step_kind = '0;
   logic              step_mode = 1'b0;
   logic              exp_level = 1'b0;
   logic              hs_in = 1'b0;
   logic              busy, done, error;
   logic [STEP_W-1:0] err_code;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   step_wait_monitor #(.CNT_W(CNT_W), .TO_W(TO_W), .NUM_KINDS(KINDS),
                       .STEP_W(STEP_W), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cnt_wr_en(cnt_wr_en), .cnt_wr_kind(cnt_wr_kind), .cnt_wr_val(cnt_wr_val),
      .tmo_wr_en(tmo_wr_en), .tmo_wr_val(tmo_wr_val),
      .start(start), .step_id(step_id), .step_kind(step_kind),
      .step_mode(step_mode), .exp_level(exp_level), .hs_in(hs_in),
      .busy(busy), .done(done), .error(error), .err_code(err_code));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_cnt(input int kind, input int val);
      @(negedge clk);
      cnt_wr_en = 1'b1; cnt_wr_kind = KW'(kind); cnt_wr_val = CNT_W'(val);
      @(negedge clk);
      cnt_wr_en = 1'b0;
   endtask

   task automatic write_tmo(input int val);
      @(negedge clk);
      tmo_wr_en = 1'b1; tmo_wr_val = TO_W'(val);
      @(negedge clk);
      tmo_wr_en = 1'b0;
   endtask

   // Starts a step, then counts edges after the accepting edge until done or
   // error. Injections happen at the negedge that follows edge k.
   task automatic run_step(input int id, input int kind, input bit mode, input bit expv,
                           input int hs_k, input bit hs_v,
                           input int wr_k, input int wr_kind, input int wr_val,
                           input int st_k,
                           output int cyc, output bit gd, output bit ge);
      int k = 0;
      gd = 0; ge = 0; cyc = -1;
      @(negedge clk);
      start = 1'b1; step_id = STEP_W'(id); step_kind = KW'(kind);
      step_mode = mode; exp_level = expv;
      @(negedge clk);
      start = 1'b0;
      while (k < 70000) begin
         cnt_wr_en = 1'b0;
         start = 1'b0;
         if (k == hs_k) hs_in = hs_v;
         if (k == wr_k) begin
            cnt_wr_en = 1'b1; cnt_wr_kind = KW'(wr_kind); cnt_wr_val = CNT_W'(wr_val);
         end
         if (k == st_k) begin
            start = 1'b1; step_id = STEP_W'(id + 1); step_kind = KW'(2);
            step_mode = 1'b1;
         end
         @(negedge clk);
         k++;
         if (done || error) begin
            cyc = k; gd = done; ge = error;
            break;
         end
      end
      cnt_wr_en = 1'b0;
      start = 1'b0;
      @(negedge clk);
      check(!done && !error && !busy, "R8 pulse ends and busy low", int'({done, error, busy}), 0);
   endtask

   task automatic t_reset();
      check(!busy && !done && !error, "R1 outputs low after reset", int'({busy, done, error}), 0);
      check(err_code == '0, "R1 err_code zero", int'(err_code), 0);
   endtask

   task automatic t_default_count();
      int c; bit d, e;
      run_step(3, 3, 1'b1, 1'b0, -1, 1'b0, -1, 0, 0, -1, c, d, e);
      check(d && !e && c == 65536, "R5 unwritten count is all ones", c, 65536);
   endtask

   task automatic t_count_mode();
      int c; bit d, e;
      write_cnt(0, 5); write_cnt(1, 100); write_cnt(2, 0);
      write_tmo(3000);
      run_step(4, 1, 1'b1, 1'b1, 10, 1'b1, -1, 0, 0, -1, c, d, e);
      check(d && c == 101, "R2 count mode N=100, handshake ignored", c, 101);
      hs_in = 1'b0;
      run_step(5, 0, 1'b1, 1'b0, -1, 1'b0, -1, 0, 0, -1, c, d, e);
      check(d && c == 6, "R4 kind 0 count selected", c, 6);
      run_step(6, 2, 1'b1, 1'b0, -1, 1'b0, -1, 0, 0, -1, c, d, e);
      check(d && c == 1, "R9 zero count finishes next cycle", c, 1);
   endtask

   task automatic t_handshake();
      int c; bit d, e;
      hs_in = 1'b0;
      run_step(7, 0, 1'b0, 1'b1, 10, 1'b1, -1, 0, 0, -1, c, d, e);
      check(d && c == 19, "R3 rising handshake d=10 N=5", c, 19);
      run_step(8, 0, 1'b0, 1'b1, -1, 1'b0, -1, 0, 0, -1, c, d, e);
      check(d && c == 7, "R3 handshake already matching", c, 7);
      run_step(9, 2, 1'b0, 1'b0, 3, 1'b0, -1, 0, 0, -1, c, d, e);
      check(d && c == 7, "R3 falling handshake d=3 N=0", c, 7);
      run_step(10, 2, 1'b0, 1'b1, -1, 1'b0, -1, 0, 0, -1, c, d, e);
      check(e && !d && c == 3001, "R3 no match leads to timeout", c, 3001);
      check(err_code == 6'd10, "R6 code of handshake step", int'(err_code), 10);
   endtask

   task automatic t_timeout();
      int c; bit d, e;
      write_tmo(50);
      write_cnt(3, 51);
      run_step(33, 3, 1'b1, 1'b0, -1, 1'b0, -1, 0, 0, -1, c, d, e);
      check(e && !d && c == 51, "R6 timeout at T+1", c, 51);
      check(err_code == 6'd33, "R6 err_code is step id", int'(err_code), 33);
      write_cnt(3, 50);
      run_step(34, 3, 1'b1, 1'b0, -1, 1'b0, -1, 0, 0, -1, c, d, e);
      check(d && !e && c == 51, "R6 done wins on same edge", c, 51);
      check(err_code == 6'd33, "R6 err_code held", int'(err_code), 33);
   endtask

   task automatic t_busy_start();
      int c; bit d, e;
      write_tmo(3000);
      run_step(20, 1, 1'b1, 1'b0, -1, 1'b0, -1, 0, 0, 5, c, d, e);
      check(d && c == 101, "R7 start while busy ignored", c, 101);
      repeat (4) begin
         @(negedge clk);
         check(!busy && !done && !error, "R7 no extra step started", int'({busy, done, error}), 0);
      end
   endtask

   task automatic t_write_busy();
      int c; bit d, e;
      run_step(40, 0, 1'b1, 1'b0, -1, 1'b0, 2, 0, 20, -1, c, d, e);
      check(d && c == 6, "R4 write during step does not change it", c, 6);
      run_step(41, 0, 1'b1, 1'b0, -1, 1'b0, -1, 0, 0, -1, c, d, e);
      check(d && c == 21, "R4 write takes effect on next step", c, 21);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_default_count();
      t_count_mode();
      t_handshake();
      t_timeout();
      t_busy_start();
      t_write_busy();
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule